// File: doc/BRIEF.md
# Bundle Template Dispatcher

The dispatcher sits between instruction fetch and the execution clusters of a wide-issue core. Each incoming 128-bit bundle carries a 5-bit template code and three 41-bit instruction slots. The template alone decides which kind of execution unit every slot is meant for: integer, memory, floating-point or branch. The template also says whether an instruction group closes inside the bundle, and at which slot. The instruction bits themselves are never looked at, so the same bits can be sent to an integer port in one bundle and to a branch port in the next.

Two bundles may be offered in one cycle, on lane 0 (older) and lane 1 (younger). Every slot goes to a registered issue port of its class. The issue port carries the payload, the lane it came from, its slot index and an end-of-group marker. When the two bundles together need more ports of one class than exist, lane 1 is refused through its ready signal and lane 0 issues alone. A bundle whose template code is reserved raises an error flag for its lane and issues nothing.

Top module: `bundle_dispatch`

## Requirements
- R1: A bundle holds the template in bits [4:0], slot 0 in [45:5], slot 1 in [86:46] and slot 2 in [127:87]. Each slot's 41 bits reach its issue port unchanged.
- R2: Template bits [4:2] select a layout of slot classes, listed as (slot 0, slot 1, slot 2): 0 = (mem, int, int), 1 = (mem, mem, int), 2 = (mem, fp, int), 3 = (mem, int, br), 4 = (int, fp, br), 5 = (br, br, br).
- R3: Layout values 6 and 7 are reserved. For an accepted bundle with such a code, err_illegal[lane] is high in the cycle after acceptance and no issue port carries that bundle.
- R4: A slot's class depends only on the template. Identical slot bits in different layouts reach ports of different classes.
- R5: Template bits [1:0] give the group stop: 0 means no stop in this bundle, and n = 1 to 3 sets iss_eog on the port that carries slot n-1. iss_eog is never high on a port whose iss_valid is low.
- R6: Issue ports 0-1 are integer, 2-3 memory, 4-5 floating-point and 6-8 branch. Slots are taken in the order lane 0 slot 0..2, then lane 1 slot 0..2, and each slot takes the lowest free port of its class. iss_lane[p] gives the lane, and iss_slot[2p+1:2p] gives the slot index.
- R7: in_ready[0] is high whenever reset is not asserted. in_ready[1] is high only when lane 0 is valid and the combined class demand of both legal bundles fits the port counts. A reserved bundle demands nothing. A lane-1 bundle that is refused is not issued.
- R8: Issue outputs are registered. They appear in the cycle after acceptance and last exactly one cycle. A cycle with no accepted bundle gives no issue-valid in the next cycle.
- R9: When two bundles fit together, both are issued in the same cycle.
- R10: Synchronous active-low reset clears every issue-valid and error output, and both ready outputs are low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 2 | Bundle valid per lane (bit 0 = older lane) |
| in_ready | output | 2 | Bundle accepted per lane |
| in_bundle0 | input | 128 | Lane 0 bundle |
| in_bundle1 | input | 128 | Lane 1 bundle |
| iss_valid | output | 9 | Issue port valid |
| iss_payload | output | 369 | 41-bit payload per port, port p at [41p+40:41p] |
| iss_lane | output | 9 | Source lane per port |
| iss_slot | output | 18 | 2-bit slot index per port |
| iss_eog | output | 9 | End-of-group marker per port |
| err_illegal | output | 2 | Reserved template seen, per lane |

## Verification
The hardest case to reach is a refusal of lane 1 caused by one class only. For example, two (mem, int, int) bundles overflow the integer ports while every other class has room, or a branch-only bundle meets one branch slot. The bench sweeps every pair of legal layouts with a range of stop codes. This brings about every overflow combination, and the stop codes put the group marker on each slot position of each lane. Each of the 32 template codes is also swept alone, and reserved codes are placed on lane 1 beside a legal lane 0.

// File: rtl/bundle_disp_pkg.sv
`timescale 1ns/1ps
// Shared types and the template layout function for the bundle dispatcher.
// Assumes three slots per bundle and a 5-bit template: [4:2] layout, [1:0] stop.
package bundle_disp_pkg;
    localparam int TMPL_W  = 5;
    localparam int SLOTS   = 3;
    localparam int LANES   = 2;
    localparam int NUM_CLS = 4;

    typedef enum logic [1:0] {
        UC_INT = 2'd0,
        UC_MEM = 2'd1,
        UC_FP  = 2'd2,
        UC_BR  = 2'd3
    } unit_cls_e;

    // Class of one slot under a given layout index (layouts 6, 7 are reserved).
    function automatic unit_cls_e layout_class(input logic [2:0] lay, input logic [1:0] s);
        unit_cls_e c;
        case (lay)
            3'd0:    c = (s == 2'd0) ? UC_MEM : UC_INT;
            3'd1:    c = (s == 2'd2) ? UC_INT : UC_MEM;
            3'd2:    c = (s == 2'd0) ? UC_MEM : ((s == 2'd1) ? UC_FP  : UC_INT);
            3'd3:    c = (s == 2'd0) ? UC_MEM : ((s == 2'd1) ? UC_INT : UC_BR);
            3'd4:    c = (s == 2'd0) ? UC_INT : ((s == 2'd1) ? UC_FP  : UC_BR);
            default: c = UC_BR;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/bundle_tmpl_decode.sv
`timescale 1ns/1ps
// Decodes one bundle template into slot classes, end-of-group flags and a
// per-class slot demand. Assumes layout codes 6 and 7 are reserved.
module bundle_tmpl_decode
    import bundle_disp_pkg::*;
(
    input  logic [TMPL_W-1:0]             tmpl,
    output logic                          legal,
    output logic [SLOTS-1:0][1:0]         cls,
    output logic [SLOTS-1:0]              eog,
    output logic [NUM_CLS-1:0][1:0]       dem
);
    assign legal = (tmpl[4:2] < 3'd6);

    // One class lookup and stop compare per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign cls[s] = layout_class(tmpl[4:2], 2'(s));
        assign eog[s] = legal && (tmpl[1:0] == 2'(s + 1));
    end

    // Count slots per class; a reserved bundle demands no port.
    always_comb begin
        dem = '0;
        if (legal) begin
            for (int s = 0; s < SLOTS; s++) begin
                dem[cls[s]] = dem[cls[s]] + 2'd1;
            end
        end
    end
endmodule

// File: rtl/bundle_port_alloc.sv
`timescale 1ns/1ps
// Maps the slots of up to two bundles onto the class-partitioned issue ports
// and decides whether the younger bundle fits next to the older one.
// Assumes ports are laid out int, mem, fp, br, lowest index filled first.
module bundle_port_alloc
    import bundle_disp_pkg::*;
#(
    parameter int SLOT_W = 41,
    parameter int N_INT  = 2,
    parameter int N_MEM  = 2,
    parameter int N_FP   = 2,
    parameter int N_BR   = 3,
    localparam int NPORT = N_INT + N_MEM + N_FP + N_BR
) (
    input  logic [LANES-1:0]                       act,
    input  logic [LANES-1:0][SLOTS-1:0][1:0]       cls,
    input  logic [LANES-1:0][SLOTS-1:0]            eog,
    input  logic [LANES-1:0][SLOTS*SLOT_W-1:0]     pay,
    input  logic [LANES-1:0][NUM_CLS-1:0][1:0]     dem,
    output logic                                   fits,
    output logic [NPORT-1:0]                       nv,
    output logic [NPORT*SLOT_W-1:0]                npay,
    output logic [NPORT-1:0]                       nlane,
    output logic [2*NPORT-1:0]                     nslot,
    output logic [NPORT-1:0]                       neog
);
    localparam int LIM  [NUM_CLS] = '{N_INT, N_MEM, N_FP, N_BR};
    localparam int BASE [NUM_CLS] = '{0, N_INT, N_INT + N_MEM, N_INT + N_MEM + N_FP};

    // Younger bundle fits only if no class exceeds its port count.
    always_comb begin
        fits = 1'b1;
        for (int k = 0; k < NUM_CLS; k++) begin
            if (int'(dem[0][k]) + int'(dem[1][k]) > LIM[k]) fits = 1'b0;
        end
    end

    // Walk slots oldest first, giving each the next free port of its class.
    always_comb begin : alloc
        int cnt [NUM_CLS];
        int p;
        int c;
        nv    = '0;
        npay  = '0;
        nlane = '0;
        nslot = '0;
        neog  = '0;
        p     = 0;
        c     = 0;
        for (int k = 0; k < NUM_CLS; k++) cnt[k] = 0;
        for (int l = 0; l < LANES; l++) begin
            for (int s = 0; s < SLOTS; s++) begin
                c = int'(cls[l][s]);
                if (act[l] && cnt[c] < LIM[c]) begin
                    p                       = BASE[c] + cnt[c];
                    cnt[c]                  = cnt[c] + 1;
                    nv[p]                   = 1'b1;
                    npay[p*SLOT_W +: SLOT_W] = pay[l][s*SLOT_W +: SLOT_W];
                    nlane[p]                = 1'(l);
                    nslot[p*2 +: 2]         = 2'(s);
                    neog[p]                 = eog[l][s];
                end
            end
        end
    end
endmodule

// File: rtl/bundle_dispatch.sv
`timescale 1ns/1ps
// Top of the bundle dispatcher: decodes both lane templates, arbitrates the
// younger lane against port capacity and registers the issue ports.
// Assumes the issue ports have no backpressure and lane 0 is always the older bundle.
module bundle_dispatch
    import bundle_disp_pkg::*;
#(
    parameter int SLOT_W = 41,
    parameter int N_INT  = 2,
    parameter int N_MEM  = 2,
    parameter int N_FP   = 2,
    parameter int N_BR   = 3,
    localparam int NPORT    = N_INT + N_MEM + N_FP + N_BR,
    localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           in_valid,
    output logic [LANES-1:0]           in_ready,
    input  logic [BUNDLE_W-1:0]        in_bundle0,
    input  logic [BUNDLE_W-1:0]        in_bundle1,
    output logic [NPORT-1:0]           iss_valid,
    output logic [NPORT*SLOT_W-1:0]    iss_payload,
    output logic [NPORT-1:0]           iss_lane,
    output logic [2*NPORT-1:0]         iss_slot,
    output logic [NPORT-1:0]           iss_eog,
    output logic [LANES-1:0]           err_illegal
);
    logic [LANES-1:0][BUNDLE_W-1:0]          bnd;
    logic [LANES-1:0]                        legal;
    logic [LANES-1:0][SLOTS-1:0][1:0]        cls;
    logic [LANES-1:0][SLOTS-1:0]             eog;
    logic [LANES-1:0][SLOTS*SLOT_W-1:0]      pay;
    logic [LANES-1:0][NUM_CLS-1:0][1:0]      dem;
    logic [LANES-1:0]                        acc;
    logic                                    fits;
    logic [NPORT-1:0]                        nv, nlane, neog;
    logic [NPORT*SLOT_W-1:0]                 npay;
    logic [2*NPORT-1:0]                      nslot;

    assign bnd[0] = in_bundle0;
    assign bnd[1] = in_bundle1;

    // One template decoder per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign pay[l] = bnd[l][BUNDLE_W-1:TMPL_W];
        bundle_tmpl_decode u_dec (
            .tmpl  (bnd[l][TMPL_W-1:0]),
            .legal (legal[l]),
            .cls   (cls[l]),
            .eog   (eog[l]),
            .dem   (dem[l])
        );
    end

    // Lane 0 always fits; lane 1 needs an older bundle beside it and spare ports.
    assign in_ready[0] = rst_n;
    assign in_ready[1] = rst_n && in_valid[0] && fits;
    assign acc         = in_valid & in_ready;

    bundle_port_alloc #(
        .SLOT_W (SLOT_W),
        .N_INT  (N_INT),
        .N_MEM  (N_MEM),
        .N_FP   (N_FP),
        .N_BR   (N_BR)
    ) u_alloc (
        .act   (acc & legal),
        .cls   (cls),
        .eog   (eog),
        .pay   (pay),
        .dem   (dem),
        .fits  (fits),
        .nv    (nv),
        .npay  (npay),
        .nlane (nlane),
        .nslot (nslot),
        .neog  (neog)
    );

    // Issue register stage; reset clears every valid and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid   <= '0;
            iss_payload <= '0;
            iss_lane    <= '0;
            iss_slot    <= '0;
            iss_eog     <= '0;
            err_illegal <= '0;
        end else begin
            iss_valid   <= nv;
            iss_payload <= npay;
            iss_lane    <= nlane;
            iss_slot    <= nslot;
            iss_eog     <= neog;
            err_illegal <= acc & ~legal;
        end
    end
endmodule

// File: rtl/bundle_dispatch_chk.sv
`timescale 1ns/1ps
// Protocol checker for the bundle dispatcher, bound onto every instance.
// Assumes the template of lane 0 occupies the low five bundle bits.
module bundle_dispatch_chk #(
    parameter int N_PORTS = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         in_valid,
    input logic [1:0]         in_ready,
    input logic [4:0]         tmpl0,
    input logic [N_PORTS-1:0] iss_valid,
    input logic [N_PORTS-1:0] iss_lane,
    input logic [N_PORTS-1:0] iss_eog,
    input logic [1:0]         err_illegal
);
    // R7: the younger lane is never taken without an older bundle.
    p_lane1_needs_lane0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[1] && !in_valid[0]) |-> !in_ready[1]);

    // R7: a refused younger bundle never shows up on a port.
    p_refused_not_issued_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[1] && !in_ready[1]) |=> ((iss_valid & iss_lane) == '0));

    // R3: a reserved lane-0 template flags an error and issues nothing from lane 0.
    p_reserved_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && tmpl0[4:2] >= 3'd6) |=> (err_illegal[0] && ((iss_valid & ~iss_lane) == '0)));

    // R8: nothing accepted means nothing issued in the next cycle.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid[0] |=> (iss_valid == '0 && err_illegal == '0));

    // R5: group marker only on a live port.
    p_eog_on_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_eog & ~iss_valid) == '0));

    // R9: at most two bundles of three slots issue at once.
    p_issue_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(iss_valid) <= 6));
endmodule

bind bundle_dispatch bundle_dispatch_chk #(.N_PORTS(NPORT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .tmpl0       (in_bundle0[4:0]),
    .iss_valid   (iss_valid),
    .iss_lane    (iss_lane),
    .iss_eog     (iss_eog),
    .err_illegal (err_illegal)
);

// File: tb/test_bundle_dispatch.sv
`timescale 1ns/1ps
// Sweeps every template code alone and every pair of legal layouts, with the
// expected port map computed from the requirement tables.
module test_bundle_dispatch;
    localparam int SW = 41;
    localparam int NP = 9;
    localparam int BW = 128;
    localparam int LT [6][3] = '{'{1,0,0}, '{1,1,0}, '{1,2,0}, '{1,0,3}, '{0,2,3}, '{3,3,3}};
    localparam int BASE [4] = '{0, 2, 4, 6};
    localparam int LIM  [4] = '{2, 2, 2, 3};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        in_valid = '0;
    logic [1:0]        in_ready;
    logic [BW-1:0]     in_bundle0 = '0, in_bundle1 = '0;
    logic [NP-1:0]     iss_valid, iss_lane, iss_eog;
    logic [NP*SW-1:0]  iss_payload;
    logic [2*NP-1:0]   iss_slot;
    logic [1:0]        err_illegal;

    logic [NP-1:0]     ev, elane, eeog;
    logic [NP*SW-1:0]  epay;
    logic [2*NP-1:0]   eslot;
    logic [1:0]        eerr, erdy;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bundle_dispatch i_bundle_dispatch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle0(in_bundle0), .in_bundle1(in_bundle1),
        .iss_valid(iss_valid), .iss_payload(iss_payload), .iss_lane(iss_lane),
        .iss_slot(iss_slot), .iss_eog(iss_eog), .err_illegal(err_illegal)
    );

    function automatic logic [SW-1:0] mkpay(int lane, int slot, int seed, bit same);
        if (same) return {seed[15:0], 25'h0AAAAAA};
        return {seed[15:0], 1'b0, 8'(lane * 3 + slot), 16'hC0DE};
    endfunction

    task automatic check(bit ok, string req, string what, logic [NP*SW-1:0] act, logic [NP*SW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Build expected ready, ports and errors from the requirement rules.
    task automatic model(bit v0, logic [4:0] t0, bit v1, logic [4:0] t1, int seed, bit same);
        int d [2][4];
        int cnt [4];
        bit lg [2];
        bit acc [2];
        logic [4:0] t [2];
        bit f;
        t[0] = t0; t[1] = t1;
        ev = '0; elane = '0; eeog = '0; epay = '0; eslot = '0;
        for (int l = 0; l < 2; l++) begin
            lg[l] = (t[l][4:2] < 3'd6);
            for (int k = 0; k < 4; k++) d[l][k] = 0;
            if (lg[l]) for (int s = 0; s < 3; s++) d[l][LT[t[l][4:2]][s]]++;
        end
        f = 1;
        for (int k = 0; k < 4; k++) if (d[0][k] + d[1][k] > LIM[k]) f = 0;
        erdy = {v0 && f, 1'b1};
        acc[0] = v0;
        acc[1] = v1 && v0 && f;
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        for (int l = 0; l < 2; l++) begin
            if (acc[l] && lg[l]) begin
                for (int s = 0; s < 3; s++) begin
                    int c;
                    int p;
                    c = LT[t[l][4:2]][s];
                    p = BASE[c] + cnt[c];
                    cnt[c]++;
                    ev[p] = 1'b1;
                    epay[p*SW +: SW] = mkpay(l, s, seed, same);
                    elane[p] = 1'(l);
                    eslot[p*2 +: 2] = 2'(s);
                    eeog[p] = (int'(t[l][1:0]) == s + 1);
                end
            end
        end
        eerr = {acc[1] && !lg[1], acc[0] && !lg[0]};
    endtask

    // One stimulus cycle: drive, check ready, check registered outputs, check idle.
    task automatic run(bit v0, logic [4:0] t0, bit v1, logic [4:0] t1, int seed, bit same, string req);
        @(negedge clk);
        in_bundle0 = {mkpay(0, 2, seed, same), mkpay(0, 1, seed, same), mkpay(0, 0, seed, same), t0};
        in_bundle1 = {mkpay(1, 2, seed, same), mkpay(1, 1, seed, same), mkpay(1, 0, seed, same), t1};
        in_valid = {v1, v0};
        model(v0, t0, v1, t1, seed, same);
        #1;
        check(in_ready == erdy, {"R7 ", req}, "ready", NP*SW'(in_ready), NP*SW'(erdy));
        @(posedge clk);
        #1 in_valid = '0;
        @(negedge clk);
        check(iss_valid == ev && iss_lane == elane && iss_slot == eslot, {"R6 R9 ", req}, "port map",
              NP*SW'({iss_valid, iss_lane, iss_slot}), NP*SW'({ev, elane, eslot}));
        check(iss_payload == epay, {"R1 R2 ", req}, "payload", iss_payload, epay);
        check(iss_eog == eeog, {"R5 ", req}, "eog", NP*SW'(iss_eog), NP*SW'(eeog));
        check(err_illegal == eerr, {"R3 ", req}, "err", NP*SW'(err_illegal), NP*SW'(eerr));
        @(negedge clk);
        check(iss_valid == '0 && err_illegal == '0, "R8", "idle after issue",
              NP*SW'({iss_valid, err_illegal}), '0);
    endtask

    initial begin
        // R10: reset holds ready low and outputs idle.
        in_valid = 2'b11;
        in_bundle0 = {123'h1, 5'd0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 2'b00 && iss_valid == '0 && err_illegal == '0, "R10", "in reset",
              NP*SW'({in_ready, iss_valid}), '0);
        in_valid = '0;
        rst_n = 1'b1;

        // R2 R3: every template code alone on lane 0.
        for (int c = 0; c < 32; c++) run(1'b1, 5'(c), 1'b0, 5'd0, c + 100, 1'b0, "R2 single");

        // R9 R7 R5: every legal layout pair with varied stop positions.
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                run(1'b1, {3'(a), 2'((a + b) % 4)}, 1'b1, {3'(b), 2'((a * b + 1) % 4)},
                    a * 6 + b, 1'b0, "R9 pair");

        // R3: reserved template on lane 1 beside a legal lane 0.
        for (int r = 6; r < 8; r++)
            for (int q = 0; q < 4; q++)
                run(1'b1, {3'(q), 2'd3}, 1'b1, {3'(r), 2'(q)}, 300 + q, 1'b0, "R3 lane1 reserved");

        // R4: identical slot bits steered only by the template.
        for (int a = 0; a < 6; a++) run(1'b1, {3'(a), 2'd0}, 1'b0, 5'd0, 77, 1'b1, "R4 same bits");

        // R7: lane 1 offered alone is refused.
        run(1'b0, 5'd0, 1'b1, 5'd4, 500, 1'b0, "R7 lane1 alone");

        // R10: reset asserted with traffic clears outputs.
        @(negedge clk);
        in_bundle0 = {123'h5, 5'd20};
        in_valid = 2'b01;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(iss_valid == '0 && in_ready == 2'b00, "R10", "reset mid-run",
              NP*SW'({in_ready, iss_valid}), '0);
        in_valid = '0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule